// File: doc/BRIEF.md
# Width-Converting Single-Channel Transfer Engine

This block moves a block of data from a source region to a destination region over two simple request/grant ports, one for reading and one for writing. The element size on each side is chosen on its own from 8, 16, 32 or 64 bits. When reads are narrower than writes, several read elements are gathered in an internal 64-bit staging word before a single write. When reads are wider, one read element is split into several writes.

The transfer is organised as frames of elements. The source address either moves forward by the read element size after every read, or steps by programmed signed element and frame strides. The destination always uses its own signed element and frame strides. If a frame's byte count is not a whole multiple of the write element size, the bytes left over at the end of the frame go out as smaller writes that cover only valid bytes.

A start pulse on an idle engine latches the whole configuration. The engine then runs until every byte has been written, or until it meets an access it cannot issue aligned.

Top module: `dma_pack_engine`

## Requirements
- R1: When the read size is smaller than the write size, the engine issues write_bytes/read_bytes reads and then one write. The first element read fills the least significant bytes of the written word.
- R2: When the read size is larger than the write size, each read is followed by read_bytes/write_bytes writes. The first of these writes carries the least significant bytes of the read element.
- R3: Size codes are 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. Every read uses the latched read size. Every write uses the latched write size, except for the frame-end writes covered by R7. Data sits right-justified in the low bits of `rd_data` and `wr_data`, and the unused upper bits of `wr_data` are zero.
- R4: With `cfg_src_incr` set, the source address advances by the read element size after each read, and both source strides are ignored.
- R5: With `cfg_src_incr` clear, the source address advances by `cfg_src_elem_step` after each read. After the last read of a frame it advances by `cfg_src_frame_step` instead. Both strides are two's complement.
- R6: After each full-size write, the destination address advances by `cfg_dst_elem_step`. After the write that completes a frame, it advances by `cfg_dst_frame_step` instead. Both strides are two's complement.
- R7: If a frame holds fewer bytes than one write element at its end, those bytes go out as consecutive writes of the read element size. Each of these writes advances the destination by its own size, except the frame's last write, which follows R6.
- R8: `busy` is high from the cycle after an accepted start until the engine returns to idle. `done` rises once elem_cnt × frame_cnt × read_bytes bytes have been written. `done` stays high until the next accepted start, and it is never high together with `busy`.
- R9: A start while busy is ignored. Changes to the configuration inputs after an accepted start do not affect the running transfer.
- R10: A read or write whose address is not aligned to its access size is never issued. Instead `err` is set and the engine returns to idle. A start with a zero element or frame count sets `err` without any access. Both `err` and `done` clear on the next accepted start.
- R11: While a request is waiting for its grant, the request stays asserted, and its address, size and write data hold steady.
- R12: After reset the engine is idle, and `busy`, `done`, `err`, `rd_req` and `wr_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cfg_rd_size | input | 2 | Read element size code |
| cfg_wr_size | input | 2 | Write element size code |
| cfg_elem_cnt | input | CNT_W | Read elements per frame |
| cfg_frame_cnt | input | CNT_W | Number of frames |
| cfg_src_base | input | ADDR_W | First source byte address |
| cfg_dst_base | input | ADDR_W | First destination byte address |
| cfg_src_incr | input | 1 | Source post-increment mode |
| cfg_src_elem_step | input | IDX_W | Signed source stride per element |
| cfg_src_frame_step | input | IDX_W | Signed source stride at frame end |
| cfg_dst_elem_step | input | IDX_W | Signed destination stride per write |
| cfg_dst_frame_step | input | IDX_W | Signed destination stride at frame end |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_size | output | 2 | Read access size code |
| rd_gnt | input | 1 | Read grant; data is taken in the same cycle |
| rd_data | input | 64 | Read data, right-justified |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_size | output | 2 | Write access size code |
| wr_data | output | 64 | Write data, right-justified |
| wr_gnt | input | 1 | Write grant |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed |
| err | output | 1 | Transfer aborted or refused |

## Verification
The bench aims at frames whose byte count leaves a tail smaller than one write element. A design that pads the tail, or writes it at full size, would put the wrong size on the port or clobber bytes past the frame. It drives both directions of width conversion and checks lane order. Swapped lanes appear as byte-reversed write data, and a wrong unpack count as missing or extra writes against the model queue. It uses negative and frame-end strides on both sides, so a design that adds the element stride as well as the frame stride lands on the wrong address. Grants are delayed at random and a second start is pulsed mid-run with scrambled configuration: a design that restarts, or reads the live inputs, strays from the expected address stream. Misaligned bases must produce `err` with no access on the offending side, and a design that issues first would show an unexpected transaction.

// File: rtl/dma_pack_pkg.sv
// Package: shared size encodings, FSM states and helpers for the
// width-converting transfer engine. Assumes a 64-bit staging word.
package dma_pack_pkg;

    localparam int LANE_BYTES = 8;
    localparam int LANE_W     = LANE_BYTES * 8;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } eng_state_e;

    // Byte count of a size code.
    function automatic logic [3:0] esize_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // Data mask covering the low bytes of a size code.
    function automatic logic [LANE_W-1:0] esize_mask(input logic [1:0] code);
        case (code)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_gen.sv
// Address stepper: loads a base address, adds a sign-extended stride on
// each step, and flags when the current address is not aligned to the
// access size given. Assumes IDX_W < ADDR_W.
module dma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    input  logic [IDX_W-1:0]  delta,
    input  logic [1:0]        acc_size,
    output logic [ADDR_W-1:0] addr,
    output logic              misaligned
);

    localparam int EXT_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] delta_ext;

    // Sign-extend the stride to the address width.
    assign delta_ext = {{EXT_W{delta[IDX_W-1]}}, delta};

    // Address register: load on start, advance on each completed access.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= base;
        else if (step) addr <= addr + delta_ext;
    end

    // Alignment check of the current address against the access size.
    always_comb begin
        case (acc_size)
            2'd0:    misaligned = 1'b0;
            2'd1:    misaligned = addr[0];
            2'd2:    misaligned = |addr[1:0];
            default: misaligned = |addr[2:0];
        endcase
    end

endmodule

// File: rtl/dma_stage_buf.sv
// Staging word: gathers right-justified read elements at the current fill
// point (lowest byte lane first) and presents the bytes at the current
// drain offset as right-justified write data. Assumes the controller never
// overfills the word nor drains past the fill point.
module dma_stage_buf
    import dma_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [1:0]        cap_size,
    input  logic [LANE_W-1:0] cap_data,
    input  logic              advance,
    input  logic [1:0]        out_size,
    output logic [3:0]        fill,
    output logic [3:0]        offset,
    output logic [LANE_W-1:0] out_data
);

    logic [3:0]        cap_bytes;
    logic [3:0]        out_bytes;
    logic [15:0]       ones;
    logic [15:0]       en_wide;
    logic [7:0]        lane_en;
    logic [LANE_W-1:0] placed;
    logic [LANE_W-1:0] word;

    assign cap_bytes = esize_bytes(cap_size);
    assign out_bytes = esize_bytes(out_size);

    // Lane enables and shifted data for the element being captured.
    assign ones    = (16'd1 << cap_bytes) - 16'd1;
    assign en_wide = ones << fill;
    assign lane_en = en_wide[7:0];
    assign placed  = (cap_data & esize_mask(cap_size)) << {fill[2:0], 3'b000};

    for (genvar i = 0; i < LANE_BYTES; i++) begin : g_lane
        logic [7:0] q;
        // One byte lane of the staging word.
        always_ff @(posedge clk) begin
            if (!rst_n)                       q <= '0;
            else if (capture && lane_en[i])   q <= placed[i*8 +: 8];
        end
        assign word[i*8 +: 8] = q;
    end

    // Fill and drain pointers, both cleared when a group is finished.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fill   <= '0;
            offset <= '0;
        end else begin
            if (capture) fill   <= fill + cap_bytes;
            if (advance) offset <= offset + out_bytes;
        end
    end

    // Right-justified bytes at the drain point, trimmed to the write size.
    assign out_data = (word >> {offset[2:0], 3'b000}) & esize_mask(out_size);

    AST_STAGE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> ({1'b0, fill} + {1'b0, cap_bytes}) <= 5'd8); // R1
    AST_STAGE_DRAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> ({1'b0, offset} + {1'b0, out_bytes}) <= {1'b0, fill}); // R2

endmodule

// File: rtl/dma_pack_engine.sv
// Single-channel transfer engine with independent read and write element
// sizes. A controller alternates between gathering read elements into the
// staging word and draining it as writes, and applies the element and frame
// strides on both sides. Assumes grants arrive only while the matching
// request is high, and read data is valid in the grant cycle.
module dma_pack_engine
    import dma_pack_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_rd_size,
    input  logic [1:0]        cfg_wr_size,
    input  logic [CNT_W-1:0]  cfg_elem_cnt,
    input  logic [CNT_W-1:0]  cfg_frame_cnt,
    input  logic [ADDR_W-1:0] cfg_src_base,
    input  logic [ADDR_W-1:0] cfg_dst_base,
    input  logic              cfg_src_incr,
    input  logic [IDX_W-1:0]  cfg_src_elem_step,
    input  logic [IDX_W-1:0]  cfg_src_frame_step,
    input  logic [IDX_W-1:0]  cfg_dst_elem_step,
    input  logic [IDX_W-1:0]  cfg_dst_frame_step,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_size,
    input  logic              rd_gnt,
    input  logic [63:0]       rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_size,
    output logic [63:0]       wr_data,
    input  logic              wr_gnt,
    output logic              busy,
    output logic              done,
    output logic              err
);

    eng_state_e state;

    // Latched configuration.
    logic [1:0]       rs_q, ws_q;
    logic [CNT_W-1:0] ecnt_q, fcnt_q;
    logic             incr_q;
    logic [IDX_W-1:0] sei_q, sfi_q, dei_q, dfi_q;

    // Progress tracking.
    logic [CNT_W-1:0] elem_i, frame_i;
    logic             frame_end_q;
    logic             final_q;

    logic [3:0]       rb, wb, wbytes, fill, offset, remain;
    logic             tail, elem_last, frame_last, group_last, group_full;
    logic [1:0]       wsz;
    logic             rd_fire, wr_fire, load;
    logic             src_mis, dst_mis;
    logic [IDX_W-1:0] src_delta, dst_delta;

    assign rb         = esize_bytes(rs_q);
    assign wb         = esize_bytes(ws_q);
    assign remain     = fill - offset;
    assign tail       = remain < wb;
    assign wsz        = tail ? rs_q : ws_q;
    assign wbytes     = esize_bytes(wsz);
    assign elem_last  = elem_i == (ecnt_q - CNT_W'(1));
    assign frame_last = frame_i == (fcnt_q - CNT_W'(1));
    assign group_last = (offset + wbytes) == fill;
    assign group_full = ({1'b0, fill} + {1'b0, rb}) >= {1'b0, wb};

    assign load    = (state == ST_IDLE) && start;
    assign rd_req  = (state == ST_READ) && !src_mis;
    assign wr_req  = (state == ST_WRITE) && !dst_mis;
    assign rd_fire = rd_req && rd_gnt;
    assign wr_fire = wr_req && wr_gnt;
    assign rd_size = rs_q;
    assign wr_size = wsz;
    assign busy    = state != ST_IDLE;

    // Source stride: element size in post-increment mode, else programmed.
    assign src_delta = incr_q    ? IDX_W'(rb) :
                       elem_last ? sfi_q      : sei_q;

    // Destination stride: frame stride on the frame's last write, own size
    // on tail writes, element stride otherwise.
    assign dst_delta = (group_last && frame_end_q) ? dfi_q :
                       tail                        ? IDX_W'(wbytes) : dei_q;

    dma_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_src_ag (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .base       (cfg_src_base),
        .step       (rd_fire),
        .delta      (src_delta),
        .acc_size   (rs_q),
        .addr       (rd_addr),
        .misaligned (src_mis)
    );

    dma_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dst_ag (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .base       (cfg_dst_base),
        .step       (wr_fire),
        .delta      (dst_delta),
        .acc_size   (wsz),
        .addr       (wr_addr),
        .misaligned (dst_mis)
    );

    dma_stage_buf u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load || (wr_fire && group_last)),
        .capture  (rd_fire),
        .cap_size (rs_q),
        .cap_data (rd_data),
        .advance  (wr_fire),
        .out_size (wsz),
        .fill     (fill),
        .offset   (offset),
        .out_data (wr_data)
    );

    // Control: start acceptance, read gathering, write draining, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            rs_q        <= '0;
            ws_q        <= '0;
            ecnt_q      <= '0;
            fcnt_q      <= '0;
            incr_q      <= 1'b0;
            sei_q       <= '0;
            sfi_q       <= '0;
            dei_q       <= '0;
            dfi_q       <= '0;
            elem_i      <= '0;
            frame_i     <= '0;
            frame_end_q <= 1'b0;
            final_q     <= 1'b0;
            done        <= 1'b0;
            err         <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        rs_q        <= cfg_rd_size;
                        ws_q        <= cfg_wr_size;
                        ecnt_q      <= cfg_elem_cnt;
                        fcnt_q      <= cfg_frame_cnt;
                        incr_q      <= cfg_src_incr;
                        sei_q       <= cfg_src_elem_step;
                        sfi_q       <= cfg_src_frame_step;
                        dei_q       <= cfg_dst_elem_step;
                        dfi_q       <= cfg_dst_frame_step;
                        elem_i      <= '0;
                        frame_i     <= '0;
                        frame_end_q <= 1'b0;
                        final_q     <= 1'b0;
                        done        <= 1'b0;
                        if ((cfg_elem_cnt == '0) || (cfg_frame_cnt == '0)) begin
                            err   <= 1'b1;
                        end else begin
                            err   <= 1'b0;
                            state <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (src_mis) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end else if (rd_gnt) begin
                        if (elem_last) begin
                            elem_i      <= '0;
                            frame_i     <= frame_i + CNT_W'(1);
                            frame_end_q <= 1'b1;
                            final_q     <= frame_last;
                        end else begin
                            elem_i      <= elem_i + CNT_W'(1);
                        end
                        if (elem_last || group_full) state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (dst_mis) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end else if (wr_gnt && group_last) begin
                        frame_end_q <= 1'b0;
                        if (frame_end_q && final_q) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R1
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr) && $stable(rd_size))); // R11
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_gnt) |=> (wr_req && $stable(wr_addr) && $stable(wr_size) && $stable(wr_data))); // R11
    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ((rd_addr[2:0] & ((3'd1 << rd_size) - 3'd1)) == 3'd0)); // R10
    AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ((wr_addr[2:0] & ((3'd1 << wr_size) - 3'd1)) == 3'd0)); // R10
    AST_WR_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ((wr_size == ws_q) || ((wr_size == rd_size) && (rd_size < ws_q)))); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_size)); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

endmodule

// File: tb/sim_dma_pack_engine.sv
`timescale 1ns/1ps
module sim_dma_pack_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  c_rs = '0, c_ws = '0;
    logic [15:0] c_ec = '0, c_fc = '0;
    logic [31:0] c_src = '0, c_dst = '0;
    logic        c_incr = 1'b0;
    logic [15:0] c_sei = '0, c_sfi = '0, c_dei = '0, c_dfi = '0;
    logic        rd_req, wr_req, busy, done, err;
    logic [31:0] rd_addr, wr_addr;
    logic [1:0]  rd_size, wr_size;
    logic        rd_gnt = 1'b0, wr_gnt = 1'b0;
    logic [63:0] rd_data = '0;
    logic [63:0] wr_data;

    int checks = 0;
    int failures = 0;
    int gnt_pct = 100;
    bit rd_strict = 1'b1;
    string cur_req = "R12";

    logic [31:0] q_rd_addr[$];
    logic [1:0]  q_rd_sz[$];
    logic [31:0] q_wr_addr[$];
    logic [1:0]  q_wr_sz[$];
    logic [63:0] q_wr_data[$];

    always #2.5 clk = ~clk;

    dma_pack_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_rd_size(c_rs), .cfg_wr_size(c_ws),
        .cfg_elem_cnt(c_ec), .cfg_frame_cnt(c_fc),
        .cfg_src_base(c_src), .cfg_dst_base(c_dst), .cfg_src_incr(c_incr),
        .cfg_src_elem_step(c_sei), .cfg_src_frame_step(c_sfi),
        .cfg_dst_elem_step(c_dei), .cfg_dst_frame_step(c_dfi),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_gnt(rd_gnt), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_gnt(wr_gnt),
        .busy(busy), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mb(input logic [31:0] a);
        return (a[7:0] * 8'd37) + a[15:8] + 8'h11;
    endfunction

    function automatic logic [63:0] mem_word(input logic [31:0] a, input logic [1:0] sz);
        logic [63:0] v = '0;
        for (int b = 0; b < (1 << sz); b++) v[b*8 +: 8] = mb(a + 32'(b));
        return v;
    endfunction

    // Behavioural reference: expected read and write streams from the requirements.
    task automatic build_model(input int rs, input int ws, input int ec, input int fc,
                               input bit incr, input longint src, input longint dst,
                               input int sei, input int sfi, input int dei, input int dfi);
        logic [7:0] fb[$];
        longint s = src;
        longint d = dst;
        int rbn = 1 << rs;
        int wbn = 1 << ws;
        for (int f = 0; f < fc; f++) begin
            int pos = 0;
            fb.delete();
            for (int e = 0; e < ec; e++) begin
                logic [63:0] v = mem_word(32'(s), 2'(rs));
                q_rd_addr.push_back(32'(s));
                q_rd_sz.push_back(2'(rs));
                for (int b = 0; b < rbn; b++) fb.push_back(v[b*8 +: 8]);
                s += incr ? rbn : ((e == ec - 1) ? sfi : sei);
            end
            while (pos < fb.size()) begin
                int sz = ((fb.size() - pos) >= wbn) ? ws : rs;
                int n = 1 << sz;
                logic [63:0] v = '0;
                bit last;
                for (int b = 0; b < n; b++) v[b*8 +: 8] = fb[pos + b];
                last = (pos + n) == fb.size();
                q_wr_addr.push_back(32'(d));
                q_wr_sz.push_back(2'(sz));
                q_wr_data.push_back(v);
                d += last ? dfi : ((sz == ws) ? dei : n);
                pos += n;
            end
        end
    endtask

    task automatic set_cfg(input int rs, input int ws, input int ec, input int fc,
                           input bit incr, input int src, input int dst,
                           input int sei, input int sfi, input int dei, input int dfi);
        c_rs = 2'(rs); c_ws = 2'(ws); c_ec = 16'(ec); c_fc = 16'(fc);
        c_incr = incr; c_src = 32'(src); c_dst = 32'(dst);
        c_sei = 16'(sei); c_sfi = 16'(sfi); c_dei = 16'(dei); c_dfi = 16'(dfi);
    endtask

    // Bus responder: grants at negedges, compares every transfer with the model.
    initial begin
        bit rd_wait = 1'b0, wr_wait = 1'b0;
        logic [31:0] rd_hold = '0, wr_hold = '0;
        logic [63:0] wd_hold = '0;
        forever begin
            @(negedge clk);
            if (rd_req) begin
                if (rd_wait && !rd_gnt)
                    check(rd_addr == rd_hold, "R11", "read addr held", 64'(rd_addr), 64'(rd_hold));
                if ($urandom_range(99) < 32'(gnt_pct)) begin
                    if (rd_strict) begin
                        if (q_rd_addr.size() == 0) begin
                            check(1'b0, cur_req, "unexpected read", 64'(rd_addr), 64'hFFFF_FFFF);
                        end else begin
                            check(rd_addr == q_rd_addr[0], cur_req, "read addr", 64'(rd_addr), 64'(q_rd_addr[0]));
                            check(rd_size == q_rd_sz[0], {cur_req, " R3"}, "read size", 64'(rd_size), 64'(q_rd_sz[0]));
                            void'(q_rd_addr.pop_front());
                            void'(q_rd_sz.pop_front());
                        end
                    end
                    rd_data = mem_word(rd_addr, rd_size);
                    rd_gnt = 1'b1;
                    rd_wait = 1'b0;
                end else begin
                    rd_gnt = 1'b0;
                    rd_wait = 1'b1;
                    rd_hold = rd_addr;
                end
            end else begin
                rd_gnt = 1'b0;
                rd_wait = 1'b0;
            end
            if (wr_req) begin
                if (wr_wait && !wr_gnt)
                    check((wr_addr == wr_hold) && (wr_data == wd_hold), "R11", "write held",
                          {wr_addr, wr_data[31:0]}, {wr_hold, wd_hold[31:0]});
                if ($urandom_range(99) < 32'(gnt_pct)) begin
                    if (q_wr_addr.size() == 0) begin
                        check(1'b0, cur_req, "unexpected write", 64'(wr_addr), 64'hFFFF_FFFF);
                    end else begin
                        check(wr_addr == q_wr_addr[0], cur_req, "write addr", 64'(wr_addr), 64'(q_wr_addr[0]));
                        check(wr_size == q_wr_sz[0], {cur_req, " R3"}, "write size", 64'(wr_size), 64'(q_wr_sz[0]));
                        check(wr_data == q_wr_data[0], cur_req, "write data", wr_data, q_wr_data[0]);
                        void'(q_wr_addr.pop_front());
                        void'(q_wr_sz.pop_front());
                        void'(q_wr_data.pop_front());
                    end
                    wr_gnt = 1'b1;
                    wr_wait = 1'b0;
                end else begin
                    wr_gnt = 1'b0;
                    wr_wait = 1'b1;
                    wr_hold = wr_addr;
                    wd_hold = wr_data;
                end
            end else begin
                wr_gnt = 1'b0;
                wr_wait = 1'b0;
            end
        end
    end

    // Launch one transfer and check its outcome (R8, R9, R10).
    task automatic run(input string req, input bit expect_err, input bit scramble);
        int cyc = 0;
        cur_req = req;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!expect_err)
            check(busy && !done && !err, "R8", "busy after start, flags cleared",
                  {61'd0, busy, done, err}, 64'd4);
        if (scramble) begin
            repeat (3) @(negedge clk);
            check(busy == 1'b1, "R9", "still busy before second start", 64'(busy), 64'd1);
            set_cfg(0, 3, 1, 1, 1'b0, 32'h0000_0FF1, 32'h0000_0FF3, 7, 9, 5, 3);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!(done || err) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        repeat (3) @(negedge clk);
        if (expect_err) begin
            check(err && !done && !busy, "R10", "error ends transfer",
                  {61'd0, err, done, busy}, 64'd4);
            check(q_wr_addr.size() == 0, "R10", "no write pending", 64'(q_wr_addr.size()), 64'd0);
        end else begin
            check(done && !err && !busy, "R8", "done held, idle",
                  {61'd0, done, err, busy}, 64'd4);
            check(q_rd_addr.size() == 0, req, "reads left", 64'(q_rd_addr.size()), 64'd0);
            check(q_wr_addr.size() == 0, req, "writes left", 64'(q_wr_addr.size()), 64'd0);
        end
        q_rd_addr.delete(); q_rd_sz.delete();
        q_wr_addr.delete(); q_wr_sz.delete(); q_wr_data.delete();
        rd_strict = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && !rd_req && !wr_req, "R12", "reset state",
              {59'd0, busy, done, err, rd_req, wr_req}, 64'd0);

        // R1 R4: 16-bit reads packed into 64-bit writes, post-increment source.
        set_cfg(1, 3, 8, 1, 1'b1, 32'h100, 32'h2000, 0, 0, 8, 0);
        build_model(1, 3, 8, 1, 1'b1, 32'h100, 32'h2000, 0, 0, 8, 0);
        run("R1 R4 R6", 1'b0, 1'b0);

        // R2 R5: 64-bit reads split into 16-bit writes, indexed source, two frames.
        set_cfg(3, 1, 4, 2, 1'b0, 32'h200, 32'h3000, 16, -40, 2, 32);
        build_model(3, 1, 4, 2, 1'b0, 32'h200, 32'h3000, 16, -40, 2, 32);
        run("R2 R5 R6", 1'b0, 1'b0);

        // R2 R6: 64-bit reads to 16-bit writes, dst element stride 4, random grants.
        gnt_pct = 40;
        set_cfg(3, 1, 32, 1, 1'b1, 32'h400, 32'h6000, 0, 0, 4, 0);
        build_model(3, 1, 32, 1, 1'b1, 32'h400, 32'h6000, 0, 0, 4, 0);
        run("R2 R6 R11", 1'b0, 1'b0);

        // R7: 6-byte frames written as one 32-bit write then two byte writes.
        set_cfg(0, 2, 6, 2, 1'b1, 32'h123, 32'h4000, 0, 0, 4, 11);
        build_model(0, 2, 6, 2, 1'b1, 32'h123, 32'h4000, 0, 0, 4, 11);
        run("R7 R6", 1'b0, 1'b0);

        // R7: 6 bytes under a 64-bit write size become three 16-bit writes.
        gnt_pct = 100;
        set_cfg(1, 3, 3, 1, 1'b1, 32'h80, 32'h5000, 0, 0, 8, 0);
        build_model(1, 3, 3, 1, 1'b1, 32'h80, 32'h5000, 0, 0, 8, 0);
        run("R7 R1", 1'b0, 1'b0);

        // R5 R3: equal 32-bit sizes, negative source element stride, three frames.
        gnt_pct = 60;
        set_cfg(2, 2, 5, 3, 1'b0, 32'h900, 32'h7000, -8, 100, 4, 12);
        build_model(2, 2, 5, 3, 1'b0, 32'h900, 32'h7000, -8, 100, 4, 12);
        run("R5 R3", 1'b0, 1'b0);

        // R9: start pulsed mid-run with scrambled configuration is ignored.
        set_cfg(0, 1, 16, 2, 1'b1, 32'hA00, 32'hB000, 0, 0, 2, 6);
        build_model(0, 1, 16, 2, 1'b1, 32'hA00, 32'hB000, 0, 0, 2, 6);
        run("R9", 1'b0, 1'b1);

        // R10: misaligned source base, no read may be issued.
        gnt_pct = 100;
        set_cfg(1, 1, 4, 1, 1'b1, 32'h101, 32'h2000, 0, 0, 2, 0);
        run("R10", 1'b1, 1'b0);

        // R10: zero element count refused.
        set_cfg(1, 1, 0, 1, 1'b1, 32'h100, 32'h2000, 0, 0, 2, 0);
        run("R10", 1'b1, 1'b0);

        // R10: misaligned destination base, no write may be issued.
        rd_strict = 1'b0;
        set_cfg(2, 2, 2, 1, 1'b1, 32'h100, 32'h2002, 0, 0, 4, 0);
        run("R10", 1'b1, 1'b0);

        // R8 R10: a clean transfer after an error clears err and completes.
        set_cfg(3, 0, 1, 1, 1'b1, 32'h38, 32'h8001, 0, 0, 1, 0);
        build_model(3, 0, 1, 1, 1'b1, 32'h38, 32'h8001, 0, 0, 1, 0);
        run("R2 R8", 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule